// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a processor bus and the programming engine of a parallel NOR flash array. It watches single-byte write cycles, each given as a word offset (already scaled for the bus width) and a command byte. It recognises the two-write unlock handshake and the commands that follow it. The result is a read-mode selector for the read multiplexer, an unlock-bypass flag, and one-clock start pulses for program, sector erase and chip erase. Each start pulse comes with the latched offset and data byte.

After a start pulse the sequencer stays busy until the execution engine returns a one-clock done pulse. While it is busy, every bus write is dropped. In unlock-bypass mode the unlock pair is skipped. Commands are then taken at any offset, and when an operation finishes the sequencer goes back to waiting for the next command instead of to idle. The unlock offsets and the query-entry offset are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the selector shows the array (read_mode 0), bypass is off, the block is not busy and no start pulse is high. The read_mode codes are: 0 array, 1 identifier, 2 query, 3 status.
- R2: A command sequence opens with 0xAA at unlock offset 0 (default 0x555), followed by 0x55 at unlock offset 1 (default 0x2AA). If either write is wrong in offset or value, the block returns to idle and bypass is cleared.
- R3: In idle, a write of 0x98 at offset 0x55 selects query mode (read_mode 2) from the next cycle. Any write while in query mode returns the block to idle with bypass cleared.
- R4: The third write 0x90 at unlock offset 0 selects identifier mode (read_mode 1). From there, 0x98 at offset 0x55 moves to query mode, and any other write returns to idle.
- R5: The third write 0xA0 arms program. The next write, at any offset and with any value, raises prog_start for one cycle and presents that offset and byte on op_addr and op_data. From the same cycle the block is busy and read_mode is 3.
- R6: A write of 0xF0 returns the block to idle and clears bypass from any non-busy state, except while program is armed. In that state 0xF0 is taken as the program data.
- R7: 0x80 as the third write, a second unlock pair, and then 0x30 at any offset raise sect_erase_start with that offset.
- R8: In the same erase sequence, 0x10 at unlock offset 0 raises chip_erase_start. 0x10 at any other offset, or any other byte, returns to idle with no pulse.
- R9: While busy, bus writes are ignored, including 0xF0. A done pulse ends the busy state: without bypass the block returns to idle. A done pulse while not busy has no effect.
- R10: Writing 0x20 as the command write sets bypass. With bypass set, the block waits directly for a command write, and that write is accepted at any offset.
- R11: When done arrives with bypass set, the block returns to waiting for a command write. Bypass stays set and read_mode shows the array.
- R12: In identifier mode with bypass set, a write of 0x00 clears bypass and returns to idle.
- R13: The three start pulses are registered one cycle after the write that triggers them. At most one of them is high at a time, and each lasts exactly one cycle.
- R14: Without bypass, a command write at an offset other than unlock offset 0 returns to idle. So does an unrecognised command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 8 | Command or data byte |
| op_done | input | 1 | Completion pulse from the execution engine |
| prog_start | output | 1 | One-cycle program start |
| sect_erase_start | output | 1 | One-cycle sector erase start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| op_addr | output | ADDR_W | Offset latched with the last start pulse |
| op_data | output | 8 | Data byte latched with the last start pulse |
| op_busy | output | 1 | Operation in progress |
| bypass_on | output | 1 | Unlock-bypass mode active |
| read_mode | output | 2 | Read selector: 0 array, 1 identifier, 2 query, 3 status |

## Verification
The assertions take wr_en and op_done to be synchronous to clk. They also assume the engine raises op_done only after it has seen a start pulse, so a done pulse can never overlap the pulse that started the operation. The stimulus changes inputs only on the falling edge. It issues done several cycles after each start, and it adds one stray done while idle to show that it is ignored. It also writes during busy periods, including 0xF0, which exercises the rule that writes are dropped while busy.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_CMD,
    ST_PGM,
    ST_AUTO,
    ST_ER_U0,
    ST_ER_U1,
    ST_ER_CMD,
    ST_BUSY,
    ST_QUERY
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } read_mode_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_t;

  localparam int unsigned NUM_OPS = 3;

  localparam logic [7:0] KEY_FIRST    = 8'hAA;
  localparam logic [7:0] KEY_SECOND   = 8'h55;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_ABORT    = 8'hF0;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_ERSETUP  = 8'h80;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_BYP_EXIT = 8'h00;

endpackage

// File: rtl/flash_seq_match.sv
module flash_seq_match
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned UNLOCK_ADDR0 = 'h555,
  parameter int unsigned UNLOCK_ADDR1 = 'h2AA,
  parameter int unsigned QUERY_ADDR   = 'h055
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              hit_ua0,
  output logic              hit_key1,
  output logic              hit_key2,
  output logic              hit_query,
  output logic              hit_abort
);

  localparam logic [ADDR_W-1:0] UA0 = ADDR_W'(UNLOCK_ADDR0);
  localparam logic [ADDR_W-1:0] UA1 = ADDR_W'(UNLOCK_ADDR1);
  localparam logic [ADDR_W-1:0] QA  = ADDR_W'(QUERY_ADDR);

  always_comb begin
    hit_ua0   = (addr == UA0);
    hit_key1  = hit_ua0 && (data == KEY_FIRST);
    hit_key2  = (addr == UA1) && (data == KEY_SECOND);
    hit_query = (addr == QA) && (data == CMD_QUERY);
    hit_abort = (data == CMD_ABORT);
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       op_done,
  input  logic       hit_ua0,
  input  logic       hit_key1,
  input  logic       hit_key2,
  input  logic       hit_query,
  input  logic       hit_abort,
  output seq_state_t state_q,
  output logic       bypass_q,
  output op_kind_t   launch
);

  seq_state_t state_d;
  logic       bypass_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    bypass_d = bypass_q;
    launch   = OP_NONE;
    if (state_q == ST_BUSY) begin
      if (op_done) begin
        state_d = bypass_q ? ST_CMD : ST_IDLE;
      end
    end else if (wr_en) begin
      if (hit_abort && state_q != ST_PGM) begin
        state_d  = ST_IDLE;
        bypass_d = 1'b0;
      end else begin
        // any path not listed falls back to idle and drops bypass
        state_d  = ST_IDLE;
        bypass_d = 1'b0;
        unique case (state_q)
          ST_IDLE: begin
            if (hit_query)     state_d = ST_QUERY;
            else if (hit_key1) state_d = ST_UNL1;
          end
          ST_UNL1: begin
            if (hit_key2) state_d = ST_CMD;
          end
          ST_CMD: begin
            if (bypass_q || hit_ua0) begin
              unique case (wr_data)
                CMD_BYPASS: begin
                  state_d  = ST_CMD;
                  bypass_d = 1'b1;
                end
                CMD_ERSETUP: begin
                  state_d  = ST_ER_U0;
                  bypass_d = bypass_q;
                end
                CMD_IDENT: begin
                  state_d  = ST_AUTO;
                  bypass_d = bypass_q;
                end
                CMD_PROGRAM: begin
                  state_d  = ST_PGM;
                  bypass_d = bypass_q;
                end
                default: ;
              endcase
            end
          end
          ST_PGM: begin
            state_d  = ST_BUSY;
            bypass_d = bypass_q;
            launch   = OP_PROG;
          end
          ST_AUTO: begin
            if (!(bypass_q && wr_data == CMD_BYP_EXIT) && hit_query) begin
              state_d  = ST_QUERY;
              bypass_d = bypass_q;
            end
          end
          ST_ER_U0: begin
            if (hit_key1) begin
              state_d  = ST_ER_U1;
              bypass_d = bypass_q;
            end
          end
          ST_ER_U1: begin
            if (hit_key2) begin
              state_d  = ST_ER_CMD;
              bypass_d = bypass_q;
            end
          end
          ST_ER_CMD: begin
            if (wr_data == CMD_CHIP && hit_ua0) begin
              state_d  = ST_BUSY;
              bypass_d = bypass_q;
              launch   = OP_CHIP;
            end else if (wr_data == CMD_SECTOR) begin
              state_d  = ST_BUSY;
              bypass_d = bypass_q;
              launch   = OP_SECT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_en = wr_en || (state_q == ST_BUSY && op_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bypass_q <= 1'b0;
    end else if (state_en) begin
      state_q  <= state_d;
      bypass_q <= bypass_d;
    end
  end

endmodule

// File: rtl/flash_seq_launch.sv
module flash_seq_launch
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  op_kind_t             launch,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           data,
  output logic [NUM_OPS-1:0]   start_q,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [7:0]           data_q
);

  logic capture;
  assign capture = (launch != OP_NONE);

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_pulse
    logic fire;
    assign fire = (launch == op_kind_t'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q[k] <= 1'b0;
      else        start_q[k] <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr;
      data_q <= data;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned UNLOCK_ADDR0 = 'h555,
  parameter int unsigned UNLOCK_ADDR1 = 'h2AA,
  parameter int unsigned QUERY_ADDR   = 'h055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output logic              prog_start,
  output logic              sect_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              op_busy,
  output logic              bypass_on,
  output logic [1:0]        read_mode
);

  logic hit_ua0, hit_key1, hit_key2, hit_query, hit_abort;
  seq_state_t state_q;
  logic bypass_q;
  op_kind_t launch;
  logic [NUM_OPS-1:0] start_q;
  read_mode_t rm;

  flash_seq_match #(
    .ADDR_W(ADDR_W), .UNLOCK_ADDR0(UNLOCK_ADDR0),
    .UNLOCK_ADDR1(UNLOCK_ADDR1), .QUERY_ADDR(QUERY_ADDR)
  ) u_match (
    .addr(wr_addr), .data(wr_data),
    .hit_ua0(hit_ua0), .hit_key1(hit_key1), .hit_key2(hit_key2),
    .hit_query(hit_query), .hit_abort(hit_abort)
  );

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .hit_ua0(hit_ua0), .hit_key1(hit_key1),
    .hit_key2(hit_key2), .hit_query(hit_query), .hit_abort(hit_abort),
    .state_q(state_q), .bypass_q(bypass_q), .launch(launch)
  );

  flash_seq_launch #(.ADDR_W(ADDR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .addr(wr_addr),
    .data(wr_data), .start_q(start_q), .addr_q(op_addr), .data_q(op_data)
  );

  always_comb begin
    unique case (state_q)
      ST_BUSY:  rm = RM_STATUS;
      ST_QUERY: rm = RM_QUERY;
      ST_AUTO:  rm = RM_IDENT;
      default:  rm = RM_ARRAY;
    endcase
  end

  assign prog_start       = start_q[int'(OP_PROG) - 1];
  assign sect_erase_start = start_q[int'(OP_SECT) - 1];
  assign chip_erase_start = start_q[int'(OP_CHIP) - 1];
  assign op_busy          = (state_q == ST_BUSY);
  assign bypass_on        = bypass_q;
  assign read_mode        = rm;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       op_done,
  input logic       prog_start,
  input logic       sect_erase_start,
  input logic       chip_erase_start,
  input logic       op_busy,
  input logic       bypass_on,
  input logic [1:0] read_mode
);

  logic any_start;
  assign any_start = prog_start | sect_erase_start | chip_erase_start;

  assert_one_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, sect_erase_start, chip_erase_start}));

  assert_pulse_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |=> !any_start);

  assert_start_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |-> $past(wr_en));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |-> op_busy);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !op_done) |=> op_busy);

  assert_query_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode == RM_QUERY && wr_en) |=> (read_mode == RM_ARRAY && !bypass_on));

  assert_bypass_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && op_done && bypass_on) |=>
      (!op_busy && bypass_on && read_mode == RM_ARRAY));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (.*);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

  localparam int AW = 12;
  localparam logic [AW-1:0] UA0 = 12'h555;
  localparam logic [AW-1:0] UA1 = 12'h2AA;
  localparam logic [AW-1:0] QA  = 12'h055;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic op_done = 1'b0;
  logic prog_start, sect_erase_start, chip_erase_start, op_busy, bypass_on;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic [1:0] read_mode;

  always #2 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .prog_start(prog_start),
    .sect_erase_start(sect_erase_start), .chip_erase_start(chip_erase_start),
    .op_addr(op_addr), .op_data(op_data), .op_busy(op_busy),
    .bypass_on(bypass_on), .read_mode(read_mode)
  );

  int vectors = 0;
  int errors = 0;
  string phase = "R1";
  bit finished = 1'b0;

  // behavioural reference: write-cycle number, latched command, flags
  int m_cyc, m_cmd;
  bit m_byp, m_busy, m_p, m_s, m_c;
  logic [AW-1:0] m_addr;
  logic [7:0] m_data;

  function automatic void m_reset_seq();
    m_cyc = 0; m_cmd = 0; m_byp = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset_seq(); m_busy = 0; m_p = 0; m_s = 0; m_c = 0;
      m_addr = '0; m_data = '0;
    end else begin
      m_p = 0; m_s = 0; m_c = 0;
      if (m_busy) begin
        if (op_done) begin
          m_busy = 0; m_cmd = 0;
          m_cyc = m_byp ? 2 : 0;
        end
      end else if (wr_en) begin
        if (wr_data == 8'hF0 && !(m_cyc == 3 && m_cmd == 'hA0)) m_reset_seq();
        else case (m_cyc)
          0: if (wr_addr == QA && wr_data == 8'h98) m_cyc = 7;
             else if (wr_addr == UA0 && wr_data == 8'hAA) m_cyc = 1;
             else m_reset_seq();
          1: if (wr_addr == UA1 && wr_data == 8'h55) m_cyc = 2; else m_reset_seq();
          2: if (!m_byp && wr_addr != UA0) m_reset_seq();
             else if (wr_data == 8'h20) m_byp = 1;
             else if (wr_data == 8'h80 || wr_data == 8'h90 || wr_data == 8'hA0) begin
               m_cmd = wr_data; m_cyc = 3;
             end else m_reset_seq();
          3: if (m_cmd == 'hA0) begin
               m_p = 1; m_busy = 1; m_addr = wr_addr; m_data = wr_data;
             end else if (m_cmd == 'h80) begin
               if (wr_addr == UA0 && wr_data == 8'hAA) m_cyc = 4; else m_reset_seq();
             end else begin
               if (m_byp && wr_data == 8'h00) m_reset_seq();
               else if (wr_addr == QA && wr_data == 8'h98) begin m_cyc = 7; m_cmd = 0; end
               else m_reset_seq();
             end
          4: if (wr_addr == UA1 && wr_data == 8'h55) m_cyc = 5; else m_reset_seq();
          5: if (wr_data == 8'h10 && wr_addr == UA0) begin
               m_c = 1; m_busy = 1; m_addr = wr_addr; m_data = wr_data;
             end else if (wr_data == 8'h30) begin
               m_s = 1; m_busy = 1; m_addr = wr_addr; m_data = wr_data;
             end else m_reset_seq();
          default: m_reset_seq();
        endcase
      end
    end
  end

  function automatic logic [1:0] m_mode();
    if (m_busy) return 2'd3;
    if (m_cyc == 7) return 2'd2;
    if (m_cyc == 3 && m_cmd == 'h90) return 2'd1;
    return 2'd0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [AW+14:0] act, exp;
      act = {prog_start, sect_erase_start, chip_erase_start, op_busy,
             bypass_on, read_mode, op_addr, op_data};
      exp = {m_p, m_s, m_c, m_busy, m_byp, m_mode(), m_addr, m_data};
      vectors++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h at %0t", phase, act, exp, $time);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(UA0, 8'hAA); wr(UA1, 8'h55);
  endtask

  task automatic done_pulse();
    repeat (3) @(negedge clk);
    op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic erase_prefix();
    unlock(); wr(UA0, 8'h80); unlock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    vectors++;
    if ({prog_start, sect_erase_start, chip_erase_start, op_busy, bypass_on, read_mode} !== 7'd0) begin
      errors++;
      $display("FAIL R1: actual %b expected 0000000",
               {prog_start, sect_erase_start, chip_erase_start, op_busy, bypass_on, read_mode});
    end

    phase = "R2";
    wr(UA0, 8'hAA); wr(12'h2AB, 8'h55); wr(UA0, 8'h90);
    wr(12'h554, 8'hAA); wr(UA1, 8'h55);
    unlock(); wr(UA0, 8'h90); wr(12'h000, 8'h11);

    phase = "R3";
    wr(QA, 8'h98); wr(12'h010, 8'h00); wr(12'h056, 8'h98);

    phase = "R4";
    unlock(); wr(UA0, 8'h90); wr(QA, 8'h98); wr(12'h020, 8'h33);

    phase = "R5";
    unlock(); wr(UA0, 8'hA0); wr(12'h123, 8'h5A); done_pulse();

    phase = "R6";
    unlock(); wr(UA0, 8'hF0);
    unlock(); wr(UA0, 8'h90); wr(12'h001, 8'hF0);
    unlock(); wr(UA0, 8'hA0); wr(12'h040, 8'hF0); done_pulse();

    phase = "R7";
    erase_prefix(); wr(12'h7C5, 8'h30); done_pulse();

    phase = "R8";
    erase_prefix(); wr(UA0, 8'h10); done_pulse();
    erase_prefix(); wr(12'h100, 8'h10);
    erase_prefix(); wr(UA0, 8'h44);

    phase = "R9";
    unlock(); wr(UA0, 8'hA0); wr(12'h0FF, 8'h00);
    wr(UA0, 8'hAA); wr(12'h000, 8'hF0); wr(QA, 8'h98);
    done_pulse(); done_pulse(); wr(UA0, 8'h90);

    phase = "R14";
    unlock(); wr(12'h556, 8'h90); unlock(); wr(UA0, 8'h77);

    phase = "R10";
    unlock(); wr(UA0, 8'h20); wr(12'h999, 8'hA0); wr(12'h300, 8'hC3);
    phase = "R11";
    done_pulse(); wr(12'h000, 8'h80); unlock(); wr(12'h222, 8'h30); done_pulse();
    phase = "R12";
    wr(12'h444, 8'h90); wr(12'h000, 8'h00); wr(UA0, 8'hA0);
    phase = "R3";
    unlock(); wr(UA0, 8'h20); wr(12'h111, 8'h90); wr(QA, 8'h98); wr(12'h000, 8'h01);
    phase = "R6";
    unlock(); wr(UA0, 8'h20); wr(12'h321, 8'hF0); wr(12'h321, 8'hA0);
    phase = "R13";
    unlock(); wr(UA0, 8'h20); wr(12'h005, 8'hA0); wr(12'h006, 8'h01); done_pulse();
    wr(12'h007, 8'hA0); wr(12'h008, 8'h02); done_pulse(); wr(12'h000, 8'hF0);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule